// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block keeps a small cache of recent virtual-page to physical-frame translations, so a memory access whose page was translated recently needs no table walk. A lookup takes a 20-bit virtual page number and a pair of access attributes: write or read, user or supervisor. From the low page bits it picks one set and compares the stored tags of all four ways at once. In the same cycle it reports one of three results: a hit, with the physical frame number and the stored permission bits; a permission miss, where the page is cached but the attributes forbid this access; or a plain miss.

On either kind of miss, the page walker outside the block resolves the translation. For a permission miss it also raises the fault. When a walk completes, the walker installs the result through the refill port. Way selection for a refill follows a fixed order. A way that already holds the same page is overwritten. Otherwise the lowest-numbered invalid way is used. If all four ways are valid, a 3-bit tree pseudo-LRU in that set names the victim. Any write of a new translation-table base address clears every entry at once.

Top module: `xlat_cache`

## Requirements
- R1: After reset, every lookup reports a miss.
- R2: The set index is page bits 3:0 (address bits 15:12). The tag is page bits 19:4 (address bits 31:16). A lookup whose tag matches a valid entry in its set returns that entry's frame number, its writable bit and its user bit in the same cycle.
- R3: While `lk_valid` is high, exactly one of `lk_hit`, `lk_miss` and `lk_perm_miss` is high. While `lk_valid` is low, all three are low.
- R4: A matching entry with writable=0 answers a write with a permission miss instead of a hit. A matching entry with user=0 answers a user access the same way.
- R5: A cycle with `base_wr` high invalidates every entry, so every lookup from the next cycle onward misses until new refills arrive.
- R6: A refill becomes visible to lookups from the cycle after it is presented. A lookup of the same page in the refill cycle still misses.
- R7: A refill for a page already cached in its set replaces that entry. The next lookup returns the new frame.
- R8: A refill into a set that is not full goes to the lowest-numbered invalid way and evicts no valid entry.
- R9: In a full set, the victim follows a 3-bit tree. Bit 0 set means the victim is in ways 2/3 and is chosen by bit 2; bit 0 clear means ways 0/1, chosen by bit 1. A refill or a hit on way w points the tree away from w. The tree starts at zero after reset and is not changed by a flush.
- R10: A refill presented in the same cycle as `base_wr` is dropped.
- R11: An entry is only found by lookups that index its own set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_write | input | 1 | Access is a write |
| lk_user | input | 1 | Access is from user privilege |
| lk_hit | output | 1 | Translation found and access allowed |
| lk_miss | output | 1 | No entry for this page |
| lk_perm_miss | output | 1 | Entry found but access forbidden |
| lk_pfn | output | 20 | Frame number of the matching entry (zero otherwise) |
| lk_perm_w | output | 1 | Cached writable bit of the matching entry |
| lk_perm_u | output | 1 | Cached user bit of the matching entry |
| fill_valid | input | 1 | Refill request from the walker |
| fill_vpn | input | 20 | Page number being installed |
| fill_pfn | input | 20 | Frame number being installed |
| fill_w | input | 1 | Writable bit being installed |
| fill_u | input | 1 | User bit being installed |
| base_wr | input | 1 | Translation-table base written: flush all entries |

## Verification
The bench fills one set, overflows it, and touches a chosen way with a hit. This checks that the page evicted is exactly the one the tree names. A design that updated the tree on misses, or pointed it at the way just used, would evict a page that should have stayed. A second set is filled to three ways while the tree still points at a valid way. A design that consulted the tree before looking for a free way would lose a live page there. The bench also looks up a page in the same cycle it is refilled, refills during a flush, and refills a page that is already cached. Getting these wrong shows up as a premature hit, a page that survives a flush, or a stale frame returned by a second copy of the page. Read-only and supervisor-only entries are probed with forbidden accesses, which a design that ignored the cached bits would report as hits.

// File: rtl/xc_pkg.sv
package xc_pkg;
  localparam int XC_WAYS   = 4;
  localparam int XC_WAY_W  = 2;
  localparam int XC_TREE_W = 3;

  // perm_t[0] = writable, perm_t[1] = user accessible
  typedef logic [1:0] perm_t;

  function automatic logic perm_allows(perm_t p, logic is_wr, logic is_usr);
    return (!is_wr || p[0]) && (!is_usr || p[1]);
  endfunction

  function automatic logic [XC_WAY_W-1:0] tree_victim(logic [XC_TREE_W-1:0] t);
    logic [XC_WAY_W-1:0] v;
    if (!t[0]) v = t[1] ? 2'd1 : 2'd0;
    else       v = t[2] ? 2'd3 : 2'd2;
    return v;
  endfunction

  function automatic logic [XC_TREE_W-1:0] tree_touch(logic [XC_TREE_W-1:0] t,
                                                      logic [XC_WAY_W-1:0] w);
    logic [XC_TREE_W-1:0] n;
    n = t;
    case (w)
      2'd0: begin n[0] = 1'b1; n[1] = 1'b1; end
      2'd1: begin n[0] = 1'b1; n[1] = 1'b0; end
      2'd2: begin n[0] = 1'b0; n[2] = 1'b1; end
      default: begin n[0] = 1'b0; n[2] = 1'b0; end
    endcase
    return n;
  endfunction

  function automatic logic [XC_WAY_W-1:0] first_clear(logic [XC_WAYS-1:0] v);
    logic [XC_WAY_W-1:0] idx;
    logic found;
    idx = '0;
    found = 1'b0;
    for (int i = 0; i < XC_WAYS; i++) begin
      if (!found && !v[i]) begin
        idx = XC_WAY_W'(i);
        found = 1'b1;
      end
    end
    return idx;
  endfunction

  function automatic logic [XC_WAY_W-1:0] onehot_index(logic [XC_WAYS-1:0] v);
    logic [XC_WAY_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < XC_WAYS; i++) begin
      if (v[i]) idx = idx | XC_WAY_W'(i);
    end
    return idx;
  endfunction
endpackage

// File: rtl/xc_way_store.sv
module xc_way_store #(
  parameter int SET_W = 4,
  parameter int TAG_W = 16,
  parameter int PFN_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [SET_W-1:0]   lk_set,
  output logic               lk_vld_o,
  output logic [TAG_W-1:0]   lk_tag_o,
  output logic [PFN_W-1:0]   lk_pfn_o,
  output xc_pkg::perm_t      lk_perm_o,
  input  logic [SET_W-1:0]   fl_set,
  output logic               fl_vld_o,
  output logic [TAG_W-1:0]   fl_tag_o,
  input  logic               wr_en,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [PFN_W-1:0]   wr_pfn,
  input  xc_pkg::perm_t      wr_perm
);
  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0]   vld_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [PFN_W-1:0]  pfn_q  [SETS];
  xc_pkg::perm_t     perm_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vld_q <= '0;
    else if (flush)  vld_q <= '0;
    else if (wr_en)  vld_q[fl_set] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      tag_q[fl_set]  <= wr_tag;
      pfn_q[fl_set]  <= wr_pfn;
      perm_q[fl_set] <= wr_perm;
    end
  end

  assign lk_vld_o  = vld_q[lk_set];
  assign lk_tag_o  = tag_q[lk_set];
  assign lk_pfn_o  = pfn_q[lk_set];
  assign lk_perm_o = perm_q[lk_set];
  assign fl_vld_o  = vld_q[fl_set];
  assign fl_tag_o  = tag_q[fl_set];

  // R5: a flush leaves no valid entry behind
  a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0));

  // R6: an accepted write makes its slot valid on the next edge
  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> vld_q[$past(fl_set)]);
endmodule

// File: rtl/xc_plru.sv
module xc_plru #(
  parameter int SET_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SET_W-1:0]            vict_set,
  output logic [xc_pkg::XC_WAY_W-1:0] victim,
  input  logic                        touch_en,
  input  logic [SET_W-1:0]            touch_set,
  input  logic [xc_pkg::XC_WAY_W-1:0] touch_way
);
  import xc_pkg::*;
  localparam int SETS = 1 << SET_W;

  logic [XC_TREE_W-1:0] tree_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (touch_en) begin
      tree_q[touch_set] <= tree_touch(tree_q[touch_set], touch_way);
    end
  end

  assign victim = tree_victim(tree_q[vict_set]);

  // R9: after a touch the set's tree no longer names the touched way
  a_r9_touch_moves_away: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (tree_victim(tree_q[$past(touch_set)]) != $past(touch_way)));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int SET_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_write,
  input  logic             lk_user,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic             lk_perm_miss,
  output logic [PFN_W-1:0] lk_pfn,
  output logic             lk_perm_w,
  output logic             lk_perm_u,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_w,
  input  logic             fill_u,
  input  logic             base_wr
);
  import xc_pkg::*;
  localparam int TAG_W = VPN_W - SET_W;

  logic [SET_W-1:0] lk_set, fill_set;
  logic [TAG_W-1:0] lk_tag, fill_tag;
  assign lk_set   = lk_vpn[SET_W-1:0];
  assign lk_tag   = lk_vpn[VPN_W-1:SET_W];
  assign fill_set = fill_vpn[SET_W-1:0];
  assign fill_tag = fill_vpn[VPN_W-1:SET_W];

  // named internal events
  logic fill_go;
  logic [XC_WAYS-1:0] lk_vld_w, lk_match, fill_vld_w, fill_match;
  logic [TAG_W-1:0]   lk_tag_w   [XC_WAYS];
  logic [TAG_W-1:0]   fill_tag_w [XC_WAYS];
  logic [PFN_W-1:0]   lk_pfn_w   [XC_WAYS];
  perm_t              lk_perm_w_a[XC_WAYS];
  logic [XC_WAY_W-1:0] hit_way, fill_way, plru_way;
  logic any_match, access_ok;
  perm_t sel_perm;
  logic [PFN_W-1:0] sel_pfn;

  assign fill_go = fill_valid && !base_wr;

  for (genvar w = 0; w < XC_WAYS; w++) begin : g_way
    xc_way_store #(.SET_W(SET_W), .TAG_W(TAG_W), .PFN_W(PFN_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (base_wr),
      .lk_set    (lk_set),
      .lk_vld_o  (lk_vld_w[w]),
      .lk_tag_o  (lk_tag_w[w]),
      .lk_pfn_o  (lk_pfn_w[w]),
      .lk_perm_o (lk_perm_w_a[w]),
      .fl_set    (fill_set),
      .fl_vld_o  (fill_vld_w[w]),
      .fl_tag_o  (fill_tag_w[w]),
      .wr_en     (fill_go && (fill_way == XC_WAY_W'(w))),
      .wr_tag    (fill_tag),
      .wr_pfn    (fill_pfn),
      .wr_perm   ({fill_u, fill_w})
    );
    assign lk_match[w]   = lk_vld_w[w] && (lk_tag_w[w] == lk_tag);
    assign fill_match[w] = fill_vld_w[w] && (fill_tag_w[w] == fill_tag);
  end

  // lookup path
  assign hit_way   = onehot_index(lk_match);
  assign any_match = |lk_match;
  assign sel_pfn   = lk_pfn_w[hit_way];
  assign sel_perm  = lk_perm_w_a[hit_way];
  assign access_ok = perm_allows(sel_perm, lk_write, lk_user);

  assign lk_hit       = lk_valid && any_match && access_ok;
  assign lk_perm_miss = lk_valid && any_match && !access_ok;
  assign lk_miss      = lk_valid && !any_match;
  assign lk_pfn       = (lk_valid && any_match) ? sel_pfn : '0;
  assign lk_perm_w    = lk_valid && any_match && sel_perm[0];
  assign lk_perm_u    = lk_valid && any_match && sel_perm[1];

  // refill way choice: same page, then free way, then tree victim
  always_comb begin
    if (|fill_match)       fill_way = onehot_index(fill_match);
    else if (!(&fill_vld_w)) fill_way = first_clear(fill_vld_w);
    else                   fill_way = plru_way;
  end

  xc_plru #(.SET_W(SET_W)) u_plru (
    .clk       (clk),
    .rst_n     (rst_n),
    .vict_set  (fill_set),
    .victim    (plru_way),
    .touch_en  (fill_go || lk_hit),
    .touch_set (fill_go ? fill_set : lk_set),
    .touch_way (fill_go ? fill_way : hit_way)
  );

  // R3: one result per lookup, none when idle
  a_r3_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> ($countones({lk_hit, lk_miss, lk_perm_miss}) == 1));
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(lk_hit || lk_miss || lk_perm_miss));
  // R7: a page never sits in two ways of its set
  a_r7_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));
  // R5: the cycle after a flush finds nothing
  a_r5_flush_misses: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |=> !(lk_hit || lk_perm_miss));
  // R6: a refilled page is found on the following cycle
  a_r6_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go |=> !(lk_valid && (lk_vpn == $past(fill_vpn)) && lk_miss));
  // R8: a set with a free way never overwrites a live entry
  a_r8_free_way_first: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_go && !(|fill_match) && !(&fill_vld_w)) |-> !fill_vld_w[fill_way]);
endmodule

// File: tb/xlat_cache_tb.sv
`timescale 1ns/1ps
module xlat_cache_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 0, lk_write = 0, lk_user = 0;
  logic [19:0] lk_vpn = '0;
  logic lk_hit, lk_miss, lk_perm_miss, lk_perm_w, lk_perm_u;
  logic [19:0] lk_pfn;
  logic fill_valid = 0, fill_w = 0, fill_u = 0, base_wr = 0;
  logic [19:0] fill_vpn = '0, fill_pfn = '0;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  xlat_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_write(lk_write), .lk_user(lk_user),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_perm_miss(lk_perm_miss),
    .lk_pfn(lk_pfn), .lk_perm_w(lk_perm_w), .lk_perm_u(lk_perm_u),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_w(fill_w), .fill_u(fill_u), .base_wr(base_wr)
  );

  typedef enum logic [1:0] {E_MISS, E_HIT, E_PERM} res_e;
  typedef struct {
    res_e        res;
    logic [19:0] pfn;
    logic        pw;
    logic        pu;
    string       req;
  } exp_t;
  exp_t sb_q[$];

  function automatic logic [19:0] mk(input logic [15:0] tag, input logic [3:0] set);
    return {tag, set};
  endfunction

  // every cycle starts one time unit after the rising edge with idle inputs
  task automatic cyc();
    @(posedge clk);
    #1;
    lk_valid = 0; lk_write = 0; lk_user = 0; lk_vpn = '0;
    fill_valid = 0; fill_w = 0; fill_u = 0; fill_vpn = '0; fill_pfn = '0;
    base_wr = 0;
  endtask

  task automatic fl(input logic [19:0] vpn, input logic [19:0] pfn,
                    input logic w, input logic u);
    fill_valid = 1; fill_vpn = vpn; fill_pfn = pfn; fill_w = w; fill_u = u;
  endtask

  // driver: present a lookup and push the expected result
  task automatic lk(input logic [19:0] vpn, input logic wr, input logic us,
                    input res_e res, input logic [19:0] pfn,
                    input logic pw, input logic pu, input string req);
    exp_t e;
    lk_valid = 1; lk_vpn = vpn; lk_write = wr; lk_user = us;
    e.res = res; e.pfn = pfn; e.pw = pw; e.pu = pu; e.req = req;
    sb_q.push_back(e);
  endtask

  // monitor: compare mid-cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && lk_valid && !done) begin
      exp_t e;
      n_checks++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard: result with no expected item (actual hit=%0b)", lk_hit);
      end else begin
        logic bad;
        e = sb_q.pop_front();
        bad = (lk_hit != (e.res == E_HIT)) || (lk_miss != (e.res == E_MISS)) ||
              (lk_perm_miss != (e.res == E_PERM));
        if (e.res == E_HIT)
          bad = bad || (lk_pfn != e.pfn) || (lk_perm_w != e.pw) || (lk_perm_u != e.pu);
        if (bad) begin
          n_fail++;
          $display("FAIL %s vpn=%h: actual hit=%0b miss=%0b perm=%0b pfn=%h w=%0b u=%0b expected res=%s pfn=%h w=%0b u=%0b",
                   e.req, lk_vpn, lk_hit, lk_miss, lk_perm_miss, lk_pfn, lk_perm_w, lk_perm_u,
                   e.res.name(), e.pfn, e.pw, e.pu);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: empty after reset
    cyc(); lk(20'h12345, 0, 0, E_MISS, 0, 0, 0, "R1");
    // R3: idle lookup raises nothing
    cyc();
    @(negedge clk);
    n_checks++;
    if (lk_hit || lk_miss || lk_perm_miss) begin
      n_fail++;
      $display("FAIL R3: actual flags=%b%b%b expected 000", lk_hit, lk_miss, lk_perm_miss);
    end

    // R6: refill not seen in its own cycle, seen the next
    cyc(); fl(mk(16'h0001, 4'h2), 20'hAAAAA, 1, 1);
           lk(mk(16'h0001, 4'h2), 0, 0, E_MISS, 0, 0, 0, "R6");
    cyc(); lk(mk(16'h0001, 4'h2), 1, 1, E_HIT, 20'hAAAAA, 1, 1, "R2");

    // R4: read-only supervisor page
    cyc(); fl(mk(16'h0002, 4'h2), 20'h0BBBB, 0, 0);
    cyc(); lk(mk(16'h0002, 4'h2), 1, 0, E_PERM, 0, 0, 0, "R4");
    cyc(); lk(mk(16'h0002, 4'h2), 0, 1, E_PERM, 0, 0, 0, "R4");
    cyc(); lk(mk(16'h0002, 4'h2), 0, 0, E_HIT, 20'h0BBBB, 0, 0, "R4");

    // R11: same tag, different set
    cyc(); lk(mk(16'h0001, 4'h3), 0, 0, E_MISS, 0, 0, 0, "R11");

    // R7: refill of a cached page replaces it
    cyc(); fl(mk(16'h0001, 4'h2), 20'h11111, 1, 0);
    cyc(); lk(mk(16'h0001, 4'h2), 0, 0, E_HIT, 20'h11111, 1, 0, "R7");

    // R5: flush
    cyc(); base_wr = 1;
    cyc(); lk(mk(16'h0001, 4'h2), 0, 0, E_MISS, 0, 0, 0, "R5");
    cyc(); lk(mk(16'h0002, 4'h2), 0, 0, E_MISS, 0, 0, 0, "R5");

    // R10: refill during flush is dropped
    cyc(); fl(mk(16'h0001, 4'h9), 20'h99999, 1, 1); base_wr = 1;
    cyc(); lk(mk(16'h0001, 4'h9), 0, 0, E_MISS, 0, 0, 0, "R10");

    // R9: pseudo-LRU victim order in set 5
    for (int t = 0; t < 4; t++) begin
      cyc(); fl(mk(16'(t), 4'h5), 20'h50000 + 20'(t), 1, 1);
    end
    cyc(); fl(mk(16'd4, 4'h5), 20'h50004, 1, 1);   // tree names way 0 (tag 0)
    cyc(); lk(mk(16'd0, 4'h5), 0, 0, E_MISS, 0, 0, 0, "R9");
    cyc(); lk(mk(16'd2, 4'h5), 0, 0, E_HIT, 20'h50002, 1, 1, "R9");
    cyc(); fl(mk(16'd5, 4'h5), 20'h50005, 1, 1);   // tree now names way 1 (tag 1)
    cyc(); lk(mk(16'd1, 4'h5), 0, 0, E_MISS, 0, 0, 0, "R9");
    for (int t = 2; t < 6; t++) begin
      cyc(); lk(mk(16'(t), 4'h5), 0, 0, E_HIT, 20'h50000 + 20'(t), 1, 1, "R9");
    end

    // R8: three ways live, tree points at a live way, fourth refill takes the free one
    for (int t = 10; t < 14; t++) begin
      cyc(); fl(mk(16'(t), 4'h7), 20'h70000 + 20'(t), 0, 1);
    end
    for (int t = 10; t < 14; t++) begin
      cyc(); lk(mk(16'(t), 4'h7), 0, 0, E_HIT, 20'h70000 + 20'(t), 0, 1, "R8");
    end

    cyc();
    repeat (3) @(posedge clk);
    #1;
    n_checks++;
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: actual %0d items left, expected 0", sb_q.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual run still busy, expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule